// File: doc/BRIEF.md
# Serial Input Delay Calibrator

This block picks the sampling delay for the receive side of a serial register-access link. When started, it tries each of four delay codes in turn (0 to 3, standing for 0, 2, 4 and 6 ns of input delay). For each code it drives that code on its delay output and issues one read of a fixed test register through a request/acknowledge port. It then compares the returned 16-bit word with the expected pattern 0x5AA5. Each match sets that code's bit in a 4-bit pass mask.

After the fourth trial the block turns the pass mask into a final code through a fixed table. A lone passing code is taken as is. A two-wide window takes the end that lies on the edge of the code range, or the lower code when neither end does. A three-wide window takes its middle code, and a full window takes code 1. Any mask whose passing codes are not adjacent, and the empty mask, is reported as a failure. The chosen code stays on the delay output until the next start, and a one-cycle done pulse marks the end of the run.

A programmable limit bounds how long a trial waits for the acknowledge. A trial that runs out of time counts as failed, so a silent back-end cannot hang the calibration.

Top module: `rxdly_cal`

## Requirements
- R1: After reset, rd_req_o, done_o and fail_o are 0, and dly_code_o and pass_mask_o are 0.
- R2: A start_i pulse while idle runs four trials with codes 0, 1, 2, 3 in that order. During each trial rd_req_o is 1, dly_code_o equals the code under test and rd_addr_o equals TEST_ADDR.
- R3: A trial passes only when rd_ack_i arrives while rd_req_o is 1 and rd_data_i equals 0x5AA5. Bit k of pass_mask_o records the result for code k. An acknowledge while idle has no effect.
- R4: If exactly one code passes (mask 0001, 0010, 0100 or 1000, bit k for code k), that code is chosen and fail_o is 0.
- R5: Two adjacent passing codes choose as follows: mask 0011 chooses 0, mask 0110 chooses 1 and mask 1100 chooses 3.
- R6: Mask 0111 chooses 1, mask 1110 chooses 2 and mask 1111 chooses 1.
- R7: Any mask not listed in R4 to R6 (0000, 0101, 1001, 1010, 1011, 1101) sets fail_o to 1 and drives code 0.
- R8: done_o is 1 for exactly one cycle, two cycles after the last trial ends. dly_code_o, fail_o and pass_mask_o then hold until the next start. start_i has no effect while a run is in progress.
- R9: A trial with no acknowledge ends after tmo_limit_i cycles of rd_req_o high (a limit of 0 acts as 1) and counts as a fail.
- R10: rd_req_o drops in the cycle after an acknowledge and stays low for exactly one cycle between trials.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a calibration run (taken only while idle) |
| tmo_limit_i | input | TMO_W | Cycles a trial waits for the acknowledge |
| rd_req_o | output | 1 | Read request to the back-end, held until acknowledge or timeout |
| rd_addr_o | output | ADDR_W | Address of the test register |
| rd_ack_i | input | 1 | Back-end acknowledge, one cycle, data valid with it |
| rd_data_i | input | DATA_W | Read data returned with the acknowledge |
| dly_code_o | output | 2 | Delay code under test, then the chosen code |
| pass_mask_o | output | 4 | Per-code trial result, bit k for code k |
| done_o | output | 1 | One-cycle end-of-run pulse |
| fail_o | output | 1 | Calibration failed (non-contiguous or empty mask) |

## Verification
From the ports, the awkward cases are non-contiguous masks and masks with a hole made by a silent back-end. Both depend on the responder's behaviour, which varies trial by trial. The bench's responder takes a per-trial pass mask and a per-trial timeout mask. It returns the pattern or a corrupted word with varied latency, or stays silent so the timer has to end the trial. All sixteen masks are walked this way. A start pulse is injected in the middle of one run to show that it does not restart the sweep.

// File: rtl/rxdly_pkg.sv
package rxdly_pkg;

    localparam int NCODE  = 4;
    localparam int CODE_W = $clog2(NCODE);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_TRIAL,
        ST_STEP
    } cal_state_e;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              fail;
    } pick_t;

    // Window table: boundary preference for two-wide windows,
    // centre for three-wide, lower centre for a full window.
    function automatic pick_t pick_delay(input logic [NCODE-1:0] m);
        pick_t p;
        p.code = '0;
        p.fail = 1'b0;
        case (m)
            4'b0001: p.code = 2'd0;
            4'b0010: p.code = 2'd1;
            4'b0100: p.code = 2'd2;
            4'b1000: p.code = 2'd3;
            4'b0011: p.code = 2'd0;
            4'b0110: p.code = 2'd1;
            4'b1100: p.code = 2'd3;
            4'b0111: p.code = 2'd1;
            4'b1110: p.code = 2'd2;
            4'b1111: p.code = 2'd1;
            default: p.fail = 1'b1;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/rxdly_timer.sv
module rxdly_timer #(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);
    logic [TMO_W-1:0] cnt_q;
    logic [TMO_W:0]   cnt_nxt;

    assign cnt_nxt = {1'b0, cnt_q} + (TMO_W+1)'(1);
    assign expired = run && (cnt_nxt >= {1'b0, limit});

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (!expired) begin
            cnt_q <= cnt_nxt[TMO_W-1:0];
        end
    end
endmodule

// File: rtl/rxdly_select.sv
module rxdly_select
    import rxdly_pkg::*;
(
    input  logic [NCODE-1:0] mask,
    output pick_t            pick
);
    always_comb begin
        pick = pick_delay(mask);
    end
endmodule

// File: rtl/rxdly_cal.sv
module rxdly_cal
    import rxdly_pkg::*;
#(
    parameter int                 DATA_W    = 16,
    parameter int                 ADDR_W    = 16,
    parameter logic [ADDR_W-1:0]  TEST_ADDR = 16'h0040,
    parameter logic [DATA_W-1:0]  PATTERN   = 16'h5AA5,
    parameter int                 TMO_W     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [TMO_W-1:0]  tmo_limit_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_ack_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [CODE_W-1:0] dly_code_o,
    output logic [NCODE-1:0]  pass_mask_o,
    output logic              done_o,
    output logic              fail_o
);
    cal_state_e        state_q;
    logic [CODE_W-1:0] code_q;
    logic [NCODE-1:0]  mask_q;
    logic              done_q;
    logic              fail_q;
    logic              tmo_hit;
    logic              in_trial;
    pick_t             pick;

    assign in_trial = (state_q == ST_TRIAL);

    rxdly_timer #(.TMO_W(TMO_W)) i_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (in_trial),
        .limit   (tmo_limit_i),
        .expired (tmo_hit)
    );

    rxdly_select i_select (
        .mask (mask_q),
        .pick (pick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            code_q  <= '0;
            mask_q  <= '0;
            done_q  <= 1'b0;
            fail_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        code_q  <= '0;
                        mask_q  <= '0;
                        fail_q  <= 1'b0;
                        state_q <= ST_TRIAL;
                    end
                end
                ST_TRIAL: begin
                    if (rd_ack_i) begin
                        mask_q[code_q] <= (rd_data_i == PATTERN);
                        state_q        <= ST_STEP;
                    end else if (tmo_hit) begin
                        mask_q[code_q] <= 1'b0;
                        state_q        <= ST_STEP;
                    end
                end
                ST_STEP: begin
                    if (code_q == CODE_W'(NCODE-1)) begin
                        code_q  <= pick.code;
                        fail_q  <= pick.fail;
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        code_q  <= code_q + CODE_W'(1);
                        state_q <= ST_TRIAL;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign rd_req_o    = in_trial;
    assign rd_addr_o   = TEST_ADDR;
    assign dly_code_o  = code_q;
    assign pass_mask_o = mask_q;
    assign done_o      = done_q;
    assign fail_o      = fail_q;
endmodule

// File: rtl/rxdly_cal_chk.sv
module rxdly_cal_chk #(
    parameter int TMO_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [TMO_W-1:0] tmo_limit_i,
    input logic             rd_req_o,
    input logic             rd_ack_i,
    input logic [1:0]       dly_code_o,
    input logic             done_o,
    input logic             fail_o
);
    logic [TMO_W:0] req_run;
    logic [TMO_W:0] lim_eff;

    assign lim_eff = (tmo_limit_i == '0) ? (TMO_W+1)'(1) : {1'b0, tmo_limit_i};

    always_ff @(posedge clk) begin
        if (rst) req_run <= '0;
        else     req_run <= rd_req_o ? req_run + (TMO_W+1)'(1) : '0;
    end

    // R1: outputs quiet in the first cycle after reset
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rd_req_o && !done_o && !fail_o));

    // R8: done is a single-cycle pulse
    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R10: request drops after an acknowledge
    a_r10_req_drop: assert property (@(posedge clk) disable iff (rst)
        (rd_req_o && rd_ack_i) |=> !rd_req_o);

    // R2: code stays put while a trial is in progress
    a_r2_code_stable: assert property (@(posedge clk) disable iff (rst)
        (rd_req_o && $past(rd_req_o)) |-> $stable(dly_code_o));

    // R7: failure flag only rises with done
    a_r7_fail_with_done: assert property (@(posedge clk) disable iff (rst)
        $rose(fail_o) |-> done_o);

    // R9: no trial outlasts its timeout
    a_r9_trial_bounded: assert property (@(posedge clk) disable iff (rst)
        rd_req_o |-> (req_run < lim_eff));
endmodule

bind rxdly_cal rxdly_cal_chk #(.TMO_W(TMO_W)) i_chk (
    .clk         (clk),
    .rst         (rst),
    .tmo_limit_i (tmo_limit_i),
    .rd_req_o    (rd_req_o),
    .rd_ack_i    (rd_ack_i),
    .dly_code_o  (dly_code_o),
    .done_o      (done_o),
    .fail_o      (fail_o)
);

// File: tb/test_rxdly_cal.sv
module test_rxdly_cal;
    localparam logic [15:0] PAT  = 16'h5AA5;
    localparam logic [15:0] ADDR = 16'h0040;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [7:0]  tmo_limit_i = 8'd8;
    logic        rd_req_o;
    logic [15:0] rd_addr_o;
    logic        rd_ack_i = 1'b0;
    logic [15:0] rd_data_i = 16'h0;
    logic [1:0]  dly_code_o;
    logic [3:0]  pass_mask_o;
    logic        done_o;
    logic        fail_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    rxdly_cal i_rxdly_cal (
        .clk(clk), .rst(rst), .start_i(start_i), .tmo_limit_i(tmo_limit_i),
        .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i),
        .rd_data_i(rd_data_i), .dly_code_o(dly_code_o), .pass_mask_o(pass_mask_o),
        .done_o(done_o), .fail_o(fail_o)
    );

    // {mask, expected code, expected fail}
    localparam logic [6:0] VEC [16] = '{
        {4'b0000, 2'd0, 1'b1}, {4'b0001, 2'd0, 1'b0},
        {4'b0010, 2'd1, 1'b0}, {4'b0011, 2'd0, 1'b0},
        {4'b0100, 2'd2, 1'b0}, {4'b0101, 2'd0, 1'b1},
        {4'b0110, 2'd1, 1'b0}, {4'b0111, 2'd1, 1'b0},
        {4'b1000, 2'd3, 1'b0}, {4'b1001, 2'd0, 1'b1},
        {4'b1010, 2'd0, 1'b1}, {4'b1011, 2'd0, 1'b1},
        {4'b1100, 2'd3, 1'b0}, {4'b1101, 2'd0, 1'b1},
        {4'b1110, 2'd2, 1'b0}, {4'b1111, 2'd1, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic string rule_tag(input logic [3:0] m, input logic f);
        if (f) return "R7";
        case ($countones(m))
            1: return "R4";
            2: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic wait_req();
        for (int k = 0; k < 40 && !rd_req_o; k++) @(negedge clk);
    endtask

    // One calibration run. m: trials answering with the pattern,
    // tmo: trials left unanswered, poke: pulse start during trial 1.
    task automatic run_cal(input logic [3:0] m, input int lat, input logic [3:0] tmo,
                           input logic poke, input logic [1:0] exp_code,
                           input logic exp_fail, input int exp_tmo_len);
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        for (int t = 0; t < 4; t++) begin
            wait_req();
            chk("R2 request per trial", {31'b0, rd_req_o}, 32'd1);
            chk("R2 code under test", {30'b0, dly_code_o}, t);
            chk("R2 test address", {16'b0, rd_addr_o}, {16'b0, ADDR});
            if (tmo[t]) begin
                int n = 1;
                for (int k = 0; k < 300 && rd_req_o; k++) begin
                    @(negedge clk);
                    if (rd_req_o) n++;
                end
                chk("R9 timeout length", n, exp_tmo_len);
            end else begin
                repeat (lat) @(negedge clk);
                if (poke && t == 1) begin
                    start_i = 1'b1;
                    @(negedge clk) start_i = 1'b0;
                    chk("R8 start ignored while busy", {30'b0, dly_code_o}, 32'd1);
                end
                rd_ack_i  = 1'b1;
                rd_data_i = m[t] ? PAT : (PAT ^ 16'h0100);
                @(negedge clk);
                rd_ack_i  = 1'b0;
                rd_data_i = 16'h0;
                chk("R10 request low after ack", {31'b0, rd_req_o}, 32'd0);
            end
            if (t < 3) begin
                @(negedge clk);
                chk("R10 gap is one cycle", {31'b0, rd_req_o}, 32'd1);
            end
        end
        chk("R8 no done before end", {31'b0, done_o}, 32'd0);
        @(negedge clk);
        chk("R8 done pulse", {31'b0, done_o}, 32'd1);
        chk("R3 pass mask", {28'b0, pass_mask_o}, {28'b0, m & ~tmo});
        chk(rule_tag(m & ~tmo, exp_fail), {30'b0, dly_code_o}, {30'b0, exp_code});
        chk(rule_tag(m & ~tmo, exp_fail), {31'b0, fail_o}, {31'b0, exp_fail});
        @(negedge clk);
        chk("R8 done one cycle", {31'b0, done_o}, 32'd0);
        chk("R8 code holds", {30'b0, dly_code_o}, {30'b0, exp_code});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 req after reset", {31'b0, rd_req_o}, 32'd0);
        chk("R1 done after reset", {31'b0, done_o}, 32'd0);
        chk("R1 fail after reset", {31'b0, fail_o}, 32'd0);
        chk("R1 code after reset", {30'b0, dly_code_o}, 32'd0);
        chk("R1 mask after reset", {28'b0, pass_mask_o}, 32'd0);

        for (int i = 0; i < 16; i++) begin
            run_cal(VEC[i][6:3], i % 4, 4'b0000, (i == 5), VEC[i][2:1], VEC[i][0], 0);
        end

        // R9: silent back-end on trial 2 leaves a hole -> mask 1011 fails
        tmo_limit_i = 8'd5;
        run_cal(4'b1111, 1, 4'b0100, 1'b0, 2'd0, 1'b1, 5);
        // R9: all trials silent, short limit
        tmo_limit_i = 8'd3;
        run_cal(4'b0000, 0, 4'b1111, 1'b0, 2'd0, 1'b1, 3);
        // R9: limit 0 behaves as 1
        tmo_limit_i = 8'd0;
        run_cal(4'b0000, 0, 4'b1111, 1'b0, 2'd0, 1'b1, 1);

        // R7 -> R4: a new run clears the failure
        tmo_limit_i = 8'd8;
        run_cal(4'b1100, 2, 4'b0000, 1'b0, 2'd3, 1'b0, 0);

        // R3: acknowledge while idle changes nothing
        @(negedge clk);
        rd_ack_i = 1'b1; rd_data_i = PAT;
        repeat (3) @(negedge clk);
        rd_ack_i = 1'b0; rd_data_i = 16'h0;
        @(negedge clk);
        chk("R3 idle ack mask", {28'b0, pass_mask_o}, 32'hC);
        chk("R3 idle ack code", {30'b0, dly_code_o}, 32'd3);
        chk("R3 idle ack req", {31'b0, rd_req_o}, 32'd0);
        chk("R8 idle no done", {31'b0, done_o}, 32'd0);
        repeat (10) @(negedge clk);
        chk("R8 hold code", {30'b0, dly_code_o}, 32'd3);
        chk("R8 hold fail", {31'b0, fail_o}, 32'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule